// File: doc/BRIEF.md
# Indexed Host Window with Interrupt Aggregation

This block is the host-side glue of a two-function communication adapter. It decodes a 32-byte I/O region. The lower half holds a few direct byte registers: two identification bytes, a combined status/control byte, an interrupt-line/serial-bus byte and a window index. The upper half, from offset 0x10, is a 16-byte window. The index picks which sub-device the window reaches: one of two HDLC channels, the line-interface FIFO, or one of two banks of line-interface registers. A host driver that wants line-interface register numbers above 0x2F selects the upper bank and sends only the low four address bits through the window.

The block gathers two external active-low interrupt inputs and one internal timer into an active-low status byte. When all three status bits read 1, the device is not the source of a shared interrupt. The shared request line is low only when the global enable is set and at least one source is active. A board-reset control bit drives a small two-state machine. In ST_RUN the sub-devices operate. A control write with bit 0 set takes the transition RUN->HOLD into ST_HOLD. ST_HOLD keeps the sub-devices in reset, clears them and blocks writes to the window. A control write with bit 0 clear takes the transition HOLD->RUN. In this project the sub-devices are stubbed as 16-byte register files.

Top module: `host_win_glue`

## Requirements
- R1: After rst_n: the index reads 0 (first HDLC channel), status at offset 2 reads 0x07, offset 3 reads 0x00, irq_n is 1 and sub_rst is 0.
- R2: Offset 0 reads the CLASS_ID parameter and offset 1 reads REV_ID. Offsets 5 to 15 read 0x00, and writes to them change nothing.
- R3: Status at offset 2 is active low. Bit 0 is the line-interface input, bit 1 the HDLC input and bit 2 the timer pending flag inverted. Bit 4 returns the stored test bit. Bits 3 and 7:5 read 0.
- R4: A control write to offset 2 stores bit 1 (timer disable), bit 2 (timer clear) and bit 3 (interrupt enable). irq_n is 0 exactly when bit 3 is set and at least one status source is active.
- R5: Offset 3 stores bits 3:0 as line_sel and bit 7 as serial_en. It reads back with bits 6:4 as 0.
- R6: Offset 4 stores bits 2:0 of the write data as the window index and reads them back with the upper bits 0.
- R7: Index codes 0, 1, 2, 4 and 6 each reach a separate 16-byte store through offsets 0x10 to 0x1F, addressed by the low 4 address bits. A write through one index never changes another.
- R8: With index 3, 5 or 7 the window reads 0x00 and writes are discarded.
- R9: sub_rst rises at the clock edge of a control write with bit 0 = 1. It falls at the edge of a control write with bit 0 = 0. While it is high, all stores are cleared and window writes are ignored.
- R10: With timer disable and clear both 0, the TMR_W-bit counter advances each cycle. The timer pending flag is set on the edge where the counter wraps, which is 2^TMR_W cycles after counting starts from zero.
- R11: While the clear bit is 1, the counter and the pending flag are held at 0. While the disable bit is 1, the count is frozen, so the wrap is only delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset in the 32-byte region |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| li_irq_n | input | 1 | Line-interface interrupt, active low |
| hdlc_irq_n | input | 1 | HDLC interrupt, active low |
| irq_n | output | 1 | Shared interrupt request, low = asserted (open-drain style) |
| sub_rst | output | 1 | Reset held on the sub-devices |
| line_sel | output | 4 | Interrupt-line select |
| serial_en | output | 1 | Serial-bus enable |

## Verification
If the index is decoded wrongly, a window byte lands in the wrong store. The cross-index sweep reports this on the first readback of a pattern that is unique to each index and address. If the board-reset machine sits in the wrong state, sub_rst shows it in the cycle after the control write, and window data survives or vanishes against expectation. A timer counter that is off by even one count moves status bit 2 by a cycle. The bench samples that bit exactly at 2^TMR_W - 1 and 2^TMR_W edges after counting starts, including a run that is paused partway through.

// File: rtl/hwg_pkg.sv
package hwg_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int WIN_AW  = 4;
    localparam int WIN_DEP = 1 << WIN_AW;
    localparam int NUM_SUB = 5;
    localparam int IDX_W   = 3;

    localparam logic [WIN_AW-1:0] OFS_CLASS = 4'd0;
    localparam logic [WIN_AW-1:0] OFS_REV   = 4'd1;
    localparam logic [WIN_AW-1:0] OFS_STAT  = 4'd2;
    localparam logic [WIN_AW-1:0] OFS_LINE  = 4'd3;
    localparam logic [WIN_AW-1:0] OFS_INDEX = 4'd4;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } brst_state_e;

    // slot 0..4 -> index code 0,1,2,4,6
    function automatic logic [IDX_W-1:0] slot_code(input int s);
        return (s < 3) ? IDX_W'(s) : IDX_W'(2 * s - 2);
    endfunction
endpackage

// File: rtl/hwg_brst_fsm.sv
module hwg_brst_fsm
    import hwg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic rst_bit,
    output logic hold
);
    brst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (ctrl_wr && rst_bit)  state_d = ST_HOLD;
            ST_HOLD: if (ctrl_wr && !rst_bit) state_d = ST_RUN;
        endcase
    end

    always_comb begin
        hold = 1'b0;
        unique case (state_q)
            ST_RUN:  hold = 1'b0;
            ST_HOLD: hold = 1'b1;
        endcase
    end
endmodule

// File: rtl/hwg_timer.sv
module hwg_timer #(
    parameter int TMR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis,
    input  logic             clr,
    output logic [TMR_W-1:0] cnt,
    output logic             pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (!dis) begin
            cnt <= cnt + 1'b1;
            if (&cnt) pend <= 1'b1;
        end
    end
endmodule

// File: rtl/hwg_stub_rf.sv
module hwg_stub_rf #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/host_win_glue.sv
module host_win_glue
    import hwg_pkg::*;
#(
    parameter int          TMR_W    = 6,
    parameter logic [7:0]  CLASS_ID = 8'hA5,
    parameter logic [7:0]  REV_ID   = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              li_irq_n,
    input  logic              hdlc_irq_n,
    output logic              irq_n,
    output logic              sub_rst,
    output logic [3:0]        line_sel,
    output logic              serial_en
);
    logic              in_win;
    logic [WIN_AW-1:0] ofs;
    logic              wr_stat, wr_line, wr_index, win_wr;

    logic              ctrl_tst, ctrl_ena, ctrl_clr, ctrl_dis;
    logic [3:0]        line_sel_q;
    logic              serial_en_q;
    logic [IDX_W-1:0]  win_idx;

    logic [TMR_W-1:0]  tmr_cnt;
    logic              tmr_pend;

    logic [NUM_SUB-1:0] hit;
    logic [BYTE_W-1:0]  sub_rd [NUM_SUB];
    logic [BYTE_W-1:0]  win_rd;
    logic [BYTE_W-1:0]  stat_byte;

    assign in_win   = bus_addr[ADDR_W-1];
    assign ofs      = bus_addr[WIN_AW-1:0];
    assign wr_stat  = bus_wr && !in_win && (ofs == OFS_STAT);
    assign wr_line  = bus_wr && !in_win && (ofs == OFS_LINE);
    assign wr_index = bus_wr && !in_win && (ofs == OFS_INDEX);
    assign win_wr   = bus_wr && in_win && !sub_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_tst    <= 1'b0;
            ctrl_ena    <= 1'b0;
            ctrl_clr    <= 1'b0;
            ctrl_dis    <= 1'b1;
            line_sel_q  <= '0;
            serial_en_q <= 1'b0;
            win_idx     <= '0;
        end else begin
            if (wr_stat) begin
                ctrl_dis <= bus_wdata[1];
                ctrl_clr <= bus_wdata[2];
                ctrl_ena <= bus_wdata[3];
                ctrl_tst <= bus_wdata[4];
            end
            if (wr_line) begin
                line_sel_q  <= bus_wdata[3:0];
                serial_en_q <= bus_wdata[7];
            end
            if (wr_index) win_idx <= bus_wdata[IDX_W-1:0];
        end
    end

    hwg_brst_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (wr_stat),
        .rst_bit (bus_wdata[0]),
        .hold    (sub_rst)
    );

    hwg_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .dis  (ctrl_dis),
        .clr  (ctrl_clr),
        .cnt  (tmr_cnt),
        .pend (tmr_pend)
    );

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
        localparam logic [IDX_W-1:0] CODE = slot_code(g);
        assign hit[g] = (win_idx == CODE);
        hwg_stub_rf #(.AW(WIN_AW), .DW(BYTE_W)) u_rf (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (sub_rst),
            .we   (win_wr && hit[g]),
            .addr (ofs),
            .wdata(bus_wdata),
            .rdata(sub_rd[g])
        );
    end

    always_comb begin
        win_rd = '0;
        for (int g = 0; g < NUM_SUB; g++)
            if (hit[g]) win_rd = sub_rd[g];
    end

    assign stat_byte = {3'b000, ctrl_tst, 1'b0, !tmr_pend, hdlc_irq_n, li_irq_n};

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            bus_rdata = win_rd;
        end else begin
            case (ofs)
                OFS_CLASS: bus_rdata = CLASS_ID;
                OFS_REV:   bus_rdata = REV_ID;
                OFS_STAT:  bus_rdata = stat_byte;
                OFS_LINE:  bus_rdata = {serial_en_q, 3'b000, line_sel_q};
                OFS_INDEX: bus_rdata = {{(BYTE_W-IDX_W){1'b0}}, win_idx};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_n     = !(ctrl_ena && (!li_irq_n || !hdlc_irq_n || tmr_pend));
    assign line_sel  = line_sel_q;
    assign serial_en = serial_en_q;
endmodule

// File: rtl/hwg_chk.sv
module hwg_chk #(
    parameter int TMR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       bus_addr,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic             sub_rst,
    input logic             irq_n,
    input logic             li_irq_n,
    input logic             hdlc_irq_n,
    input logic [TMR_W-1:0] tmr_cnt,
    input logic             tmr_pend,
    input logic             tmr_clr,
    input logic             tmr_dis,
    input logic [2:0]       win_idx
);
    // R9
    brst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_rst) |-> $past(bus_wr && bus_addr == 5'd2 && bus_wdata[0]));

    // R9
    brst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sub_rst) |-> $past(bus_wr && bus_addr == 5'd2 && !bus_wdata[0]));

    // R4
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (li_irq_n && hdlc_irq_n && !tmr_pend) |-> irq_n);

    // R6
    idx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_idx != $past(win_idx)) |-> $past(bus_wr && bus_addr == 5'd4));

    // R10
    tmr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_pend) |-> ((&$past(tmr_cnt)) && $past(!tmr_dis) && $past(!tmr_clr)));

    // R11
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_clr) |-> (tmr_cnt == '0 && !tmr_pend));

    // R11
    tmr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_dis && !tmr_clr) |=> $stable(tmr_cnt));
endmodule

bind host_win_glue hwg_chk #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .sub_rst   (sub_rst),
    .irq_n     (irq_n),
    .li_irq_n  (li_irq_n),
    .hdlc_irq_n(hdlc_irq_n),
    .tmr_cnt   (tmr_cnt),
    .tmr_pend  (tmr_pend),
    .tmr_clr   (ctrl_clr),
    .tmr_dis   (ctrl_dis),
    .win_idx   (win_idx)
);

// File: tb/host_win_glue_bench.sv
`timescale 1ns/1ps
module host_win_glue_bench;
    localparam int TMR_W = 6;
    localparam int TPER  = 1 << TMR_W;
    localparam logic [7:0] CID = 8'hA5;
    localparam logic [7:0] RID = 8'h03;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       li_irq_n = 1'b1;
    logic       hdlc_irq_n = 1'b1;
    logic       irq_n, sub_rst, serial_en;
    logic [3:0] line_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    host_win_glue #(.TMR_W(TMR_W), .CLASS_ID(CID), .REV_ID(RID)) u_host_win_glue (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .li_irq_n(li_irq_n),
        .hdlc_irq_n(hdlc_irq_n), .irq_n(irq_n), .sub_rst(sub_rst),
        .line_sel(line_sel), .serial_en(serial_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int idx, input int a);
        return 8'((idx * 37 + a * 11 + 1) ^ 8'h5A);
    endfunction

    function automatic bit idx_ok(input int idx);
        return idx == 0 || idx == 1 || idx == 2 || idx == 4 || idx == 6;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(5'd4, v); chk("R1 index", v, 8'h00);
        rd(5'd2, v); chk("R1 status", v, 8'h07);
        rd(5'd3, v); chk("R1 line", v, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 sub_rst", {7'd0, sub_rst}, 8'h00);

        // R2 identification and unused offsets
        rd(5'd0, v); chk("R2 class", v, CID);
        rd(5'd1, v); chk("R2 rev", v, RID);
        for (int a = 5; a < 16; a++) begin
            wr(5'(a), 8'hFF);
            rd(5'(a), v); chk("R2 unused", v, 8'h00);
        end

        // R5 line select / serial enable
        wr(5'd3, 8'hFF);
        rd(5'd3, v); chk("R5 readback", v, 8'h8F);
        chk("R5 pins", {3'd0, serial_en, line_sel}, 8'h1F);
        wr(5'd3, 8'h05);
        rd(5'd3, v); chk("R5 readback2", v, 8'h05);
        chk("R5 pins2", {3'd0, serial_en, line_sel}, 8'h05);

        // R6 R7 R8 window sweep
        for (int idx = 0; idx < 8; idx++) begin
            wr(5'd4, 8'hF8 | 8'(idx));
            rd(5'd4, v); chk("R6 index", v, 8'(idx));
            for (int a = 0; a < 16; a++) wr(5'(16 + a), pat(idx, a));
        end
        for (int idx = 0; idx < 8; idx++) begin
            wr(5'd4, 8'(idx));
            for (int a = 0; a < 16; a++) begin
                rd(5'(16 + a), v);
                if (idx_ok(idx)) chk("R7 window", v, pat(idx, a));
                else             chk("R8 unmapped", v, 8'h00);
            end
        end

        // R3 R4 status and interrupt
        wr(5'd2, 8'h0A);
        for (int c = 0; c < 4; c++) begin
            li_irq_n = c[0]; hdlc_irq_n = c[1];
            rd(5'd2, v); chk("R3 status", v, {5'b00000, 1'b1, c[1], c[0]});
            chk("R4 irq en", {7'd0, irq_n}, {7'd0, c[0] & c[1]});
        end
        wr(5'd2, 8'h02);
        for (int c = 0; c < 4; c++) begin
            li_irq_n = c[0]; hdlc_irq_n = c[1];
            #1 chk("R4 irq dis", {7'd0, irq_n}, 8'h01);
        end
        li_irq_n = 1'b1; hdlc_irq_n = 1'b1;
        wr(5'd2, 8'h12);
        rd(5'd2, v); chk("R3 test bit", v, 8'h17);

        // R10 timer wrap timing
        wr(5'd2, 8'h06);
        idle(2);
        wr(5'd2, 8'h00);
        idle(TPER - 1);
        rd(5'd2, v); chk("R10 before wrap", v, 8'h07);
        idle(1);
        rd(5'd2, v); chk("R10 at wrap", v, 8'h03);
        chk("R4 irq off", {7'd0, irq_n}, 8'h01);
        wr(5'd2, 8'h08);
        #1 chk("R4 irq timer", {7'd0, irq_n}, 8'h00);

        // R11 clear and freeze
        wr(5'd2, 8'h04);
        idle(1);
        rd(5'd2, v); chk("R11 cleared", v, 8'h07);
        idle(TPER + 5);
        rd(5'd2, v); chk("R11 held", v, 8'h07);
        wr(5'd2, 8'h00);
        idle(10);
        wr(5'd2, 8'h02);
        idle(TPER + 20);
        rd(5'd2, v); chk("R11 frozen", v, 8'h07);
        wr(5'd2, 8'h00);
        idle(TPER - 12 - 1);
        rd(5'd2, v); chk("R11 resume before", v, 8'h07);
        idle(1);
        rd(5'd2, v); chk("R11 resume wrap", v, 8'h03);

        // R9 board reset
        wr(5'd2, 8'h06);
        wr(5'd4, 8'h00);
        wr(5'd19, 8'h77);
        rd(5'd19, v); chk("R9 pre", v, 8'h77);
        wr(5'd2, 8'h03);
        chk("R9 sub_rst on", {7'd0, sub_rst}, 8'h01);
        idle(1);
        rd(5'd19, v); chk("R9 cleared", v, 8'h00);
        wr(5'd19, 8'h55);
        rd(5'd19, v); chk("R9 write blocked", v, 8'h00);
        wr(5'd2, 8'h02);
        chk("R9 sub_rst off", {7'd0, sub_rst}, 8'h00);
        rd(5'd19, v); chk("R9 still clear", v, 8'h00);
        wr(5'd19, 8'h55);
        rd(5'd19, v); chk("R9 write after", v, 8'h55);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule